// File: doc/BRIEF.md
# Word-Gated CRC-16 Link Checker

This block keeps a running CRC-16 over the data words carried by serial write frames, so a host can read back a signature and compare it with one it computed itself. Serial bits arrive one per qualified clock (`bit_vld`) while `frame_act` is high. The frame decoder that feeds the block pulses `data_start` with the first data bit and, in that same cycle, states whether the frame is a write and whether it is a streaming frame. Instruction and address bits, which come before `data_start`, never reach the checksum.

Incoming data bits are shifted most-significant-bit first into a shadow word. The visible CRC register is folded with that word only when all of its bits have arrived. A single-command write contributes at most one word. A streaming write contributes every complete word. Leftover bits at the end of a frame are dropped. A one-cycle `rd_clr` strobe, raised when the host reads the register, sets the value back to the seed. Between clears the CRC keeps accumulating across frames.

Top module: `word_crc_checker`

## Requirements
- R1: After reset `crc_out` equals 0xFFFF.
- R2: A cycle with `rd_clr` high makes `crc_out` 0xFFFF in the next cycle. If a word completes in the same cycle, the clear wins and that word is lost.
- R3: Each completed word is folded with the non-reflected CRC over x^16+x^12+x^5+1 (0x1021). The first data bit received is the word's bit 15, and no final XOR is applied.
- R4: Valid bits inside a frame that come before the `data_start` cycle do not affect the CRC.
- R5: In a single-command write (`is_stream`=0 at `data_start`) only the first 16 data bits count. Further bits in that frame are ignored.
- R6: In a streaming write every complete 16-bit word updates the CRC in arrival order. A trailing remainder shorter than 16 bits is discarded.
- R7: `crc_out` does not change while a word is incomplete. It changes only in the cycle after the 16th bit of a word is accepted.
- R8: A frame with `is_write`=0 at `data_start` leaves the CRC unchanged.
- R9: The CRC carries over from one write frame to the next until a clear.
- R10: Cycles with `bit_vld` low are skipped. Dropping `frame_act` discards a partial word, so the next frame starts on a fresh word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_act | input | 1 | High for the whole of a serial frame |
| data_start | input | 1 | High with the first data bit of the frame |
| is_write | input | 1 | Frame is a write; sampled at `data_start` |
| is_stream | input | 1 | Frame is streaming; sampled at `data_start` |
| bit_vld | input | 1 | `bit_in` carries a bit this cycle |
| bit_in | input | 1 | Serial data bit |
| rd_clr | input | 1 | Host read of the CRC; resets it to the seed |
| crc_out | output | 16 | Committed CRC value |

## Verification
The bench builds the block with its default parameters: a 16-bit CRC, polynomial 0x1021, seed 0xFFFF and 16-bit data words. With these values, frames of up to 48 data bits cover one, two and three complete words, remainders of several lengths, single-command frames with surplus bits, and read frames. A bench-side model folds each word in a single whole-word step rather than bit by bit. Directed cases place a clear on the completing bit, check the register part way through a word, and abort a frame mid-word.

// File: rtl/word_crc_checker.sv
module word_crc_checker #(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF,
  parameter int WORD_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_act,
  input  logic             data_start,
  input  logic             is_write,
  input  logic             is_stream,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             rd_clr,
  output logic [CRC_W-1:0] crc_out
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CRC_W-1:0]     crc_q;
  logic [WORD_BITS-1:0] shadow_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 in_data_q, wr_q, st_q, done_q;

  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c_in,
                                            input logic [WORD_BITS-1:0] w);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = WORD_BITS - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ w[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  wire                 wr_eff    = data_start ? is_write  : wr_q;
  wire                 st_eff    = data_start ? is_stream : st_q;
  wire                 done_eff  = data_start ? 1'b0      : done_q;
  wire [CNT_W-1:0]     base_cnt  = data_start ? '0        : cnt_q;
  wire                 take      = frame_act && bit_vld && (data_start || in_data_q)
                                   && wr_eff && !done_eff;
  wire                 word_full = take && (base_cnt == LAST);
  wire [WORD_BITS-1:0] next_word = {shadow_q[WORD_BITS-2:0], bit_in};

  assign crc_out = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= SEED;
    else if (rd_clr)         crc_q <= SEED;
    else if (word_full)      crc_q <= fold(crc_q, next_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      cnt_q     <= '0;
      in_data_q <= 1'b0;
      wr_q      <= 1'b0;
      st_q      <= 1'b0;
      done_q    <= 1'b0;
    end else if (!frame_act) begin
      cnt_q     <= '0;
      in_data_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (data_start) begin
        in_data_q <= 1'b1;
        wr_q      <= is_write;
        st_q      <= is_stream;
      end
      if (take) shadow_q <= next_word;
      if (word_full)   cnt_q <= '0;
      else if (take)   cnt_q <= base_cnt + 1'b1;
      else             cnt_q <= base_cnt;
      done_q <= done_eff || (word_full && !st_eff);
    end
  end

  assert_seed_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (crc_q == SEED));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !(frame_act && bit_vld)) |=> $stable(crc_q));

  assert_prefix_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && !data_start && !in_data_q && !rd_clr) |=> $stable(crc_q));

  assert_read_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && in_data_q && !data_start && !wr_q && !rd_clr) |=> $stable(crc_q));

  assert_single_extra_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && done_q && !data_start && !rd_clr) |=> $stable(crc_q));

  assert_partial_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_start && cnt_q != LAST && !rd_clr) |=> $stable(crc_q));

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: tb/tb_word_crc_checker.sv
module tb_word_crc_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_act = 0, data_start = 0, is_write = 0, is_stream = 0;
  logic bit_vld = 0, bit_in = 0, rd_clr = 0;
  logic [15:0] crc_out;
  int errors = 0, checks = 0;
  logic [15:0] model = 16'hFFFF;

  always #10 clk = ~clk;

  word_crc_checker dut (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .data_start(data_start),
    .is_write(is_write), .is_stream(is_stream), .bit_vld(bit_vld), .bit_in(bit_in),
    .rd_clr(rd_clr), .crc_out(crc_out));

  localparam int NV = 8;
  localparam logic       V_WR  [0:NV-1] = '{1, 1, 1, 1, 0, 1, 1, 1};
  localparam logic       V_ST  [0:NV-1] = '{0, 0, 1, 1, 0, 1, 1, 0};
  localparam logic       V_CLR [0:NV-1] = '{1, 0, 1, 0, 0, 1, 0, 0};
  localparam int         V_N   [0:NV-1] = '{16, 20, 32, 40, 16, 10, 48, 24};
  localparam logic [47:0] V_D  [0:NV-1] = '{
    48'h1234_0000_0000, 48'hBEEF_A000_0000, 48'h0001_FFFE_0000, 48'hC0DE_5A5A_7700,
    48'h8421_0000_0000, 48'h3FC0_0000_0000, 48'hDEAD_BEEF_0F0F, 48'h9999_6600_0000};

  function automatic logic [15:0] word_step(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c ^ w;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [15:0] frame_model(input logic [15:0] c, input logic wr,
                                              input logic st, input int n,
                                              input logic [47:0] d);
    int words;
    logic [15:0] r;
    r = c;
    if (!wr) return r;
    words = st ? n / 16 : (n >= 16 ? 1 : 0);
    for (int k = 0; k < words; k++) r = word_step(r, d[47 - 16*k -: 16]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_pulse();
    @(negedge clk) rd_clr = 1;
    @(negedge clk) rd_clr = 0;
    model = 16'hFFFF;
  endtask

  // sends 8 prefix bits, then n data bits; clr_bit >= 0 raises rd_clr with that bit
  task automatic send(input logic wr, input logic st, input int n, input logic [47:0] d,
                      input int clr_bit, input bit mid_chk, input logic [15:0] mid_exp);
    logic [7:0] pre;
    pre = 8'hC3;
    @(negedge clk);
    frame_act = 1;
    for (int i = 0; i < 8; i++) begin
      bit_vld = 1; bit_in = pre[7 - i];
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      if (mid_chk && i == 15) chk("R7 partial word held", crc_out, mid_exp);
      data_start = (i == 0);
      is_write = (i == 0) ? wr : 1'b0;
      is_stream = (i == 0) ? st : 1'b0;
      rd_clr = (i == clr_bit);
      bit_vld = 1; bit_in = d[47 - i];
      @(negedge clk);
      data_start = 0; rd_clr = 0;
      if (i == 5) begin
        bit_vld = 0; bit_in = ~bit_in;
        @(negedge clk);
      end
    end
    bit_vld = 0; frame_act = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset seed", crc_out, 16'hFFFF);
    rst_n = 1;
    @(negedge clk);
    chk("R1 seed after release", crc_out, 16'hFFFF);

    for (int v = 0; v < NV; v++) begin
      if (V_CLR[v]) clear_pulse();
      send(V_WR[v], V_ST[v], V_N[v], V_D[v], -1, 1'b0, 16'h0);
      model = frame_model(model, V_WR[v], V_ST[v], V_N[v], V_D[v]);
      chk($sformatf("R3 R4 R5 R6 R8 R9 R10 vector %0d", v), crc_out, model);
    end

    send(1, 0, 16, 48'h5555_0000_0000, -1, 1'b0, 16'h0);
    model = word_step(model, 16'h5555);
    clear_pulse();
    chk("R2 read strobe reseeds", crc_out, 16'hFFFF);

    send(1, 1, 32, 48'hA1B2_C3D4_0000, -1, 1'b1, 16'hFFFF);
    model = frame_model(16'hFFFF, 1, 1, 32, 48'hA1B2_C3D4_0000);
    chk("R6 R7 two stream words", crc_out, model);

    send(1, 0, 16, 48'h7E7E_0000_0000, 15, 1'b0, 16'h0);
    model = 16'hFFFF;
    chk("R2 clear wins over completing word", crc_out, model);

    send(1, 1, 9, 48'hFF80_0000_0000, -1, 1'b0, 16'h0);
    chk("R10 aborted partial discarded", crc_out, model);
    send(1, 0, 16, 48'h0F0F_0000_0000, -1, 1'b0, 16'h0);
    model = word_step(model, 16'h0F0F);
    chk("R10 R9 realigned after abort", crc_out, model);

    send(0, 1, 32, 48'hFFFF_FFFF_0000, -1, 1'b0, 16'h0);
    chk("R8 streaming read frame", crc_out, model);

    clear_pulse();
    send(1, 0, 16, 48'h0000_0000_0000, -1, 1'b0, 16'h0);
    chk("R3 zero word from seed", crc_out, word_step(16'hFFFF, 16'h0000));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule